// File: doc/BRIEF.md
# Buffered SPI Master Serial Engine

This block is the serial engine of an SPI master. A host writes 8-bit characters into a transmit holding register. Each character moves into a single shift register only when that register has finished with the previous one. The shift register sends bits out on MOSI and, in the same positions, collects the bits that arrive on MISO. Each received character is placed in a small receive queue, which the host drains one entry per read.

The host side is a plain register port: a write strobe with data, a read strobe with the oldest received character, and two status flags. One flag shows that the transmit holding register is empty. The other shows that received data is waiting. There is also a sticky flag that records a lost character. Static control inputs select:
- receiver enable,
- bit order,
- clock polarity and phase (all four SPI modes),
- whether the block drives the active-low slave select itself.

SCK is derived from the system clock by a fixed half-period divider.

Top module: `spi_master_engine`

## Requirements
- R1: A write while `tx_empty` is 1 is accepted, and `tx_empty` reads 0 in the next cycle. The character moves into the shift register only once that register is idle or has just finished its last bit. `tx_empty` returns to 1 in the cycle after the move.
- R2: A write while `tx_empty` is 0 is dropped. The character never appears on MOSI, and the character already held is the one that gets sent.
- R3: Each character is 8 bits. With `lsb_first` = 0 bit 7 is sent first, and with `lsb_first` = 1 bit 0 is sent first. The received character is assembled in the same order from the MISO bits, one MISO bit per MOSI bit.
- R4: SCK rests at the level of `cpol` between transfers and gives 8 pulses per character. With `cpha` = 0, data is sampled on the edge leaving the rest level and changed on the edge returning to it. With `cpha` = 1 these roles swap. Each SCK half period lasts `HALF_DIV` system clocks.
- R5: With `rx_enable` = 1, a finished character enters a two-entry FIFO in the cycle of its last sampling edge, and `rx_ready` reads 1 from the next cycle. `rd_data` shows the oldest entry, and `rd_en` removes it. `rx_ready` returns to 0 on its own once reads have emptied the FIFO.
- R6: With `rx_enable` = 0, finished characters are discarded and `rx_ready` does not change.
- R7: A character that finishes while both FIFO entries are full, with no read in that cycle, is dropped. `rx_overflow` then becomes 1 and stays 1 until reset.
- R8: With `hw_ss` = 1, `ss_n` falls `HALF_DIV` clocks before the first SCK edge. It stays low between characters whenever the next one was written in time, and rises `HALF_DIV` clocks after the final SCK edge. With `hw_ss` = 0, `ss_n` stays 1.
- R9: After reset:
  - `tx_empty` = 1, `rx_ready` = 0, `rx_overflow` = 0;
  - `ss_n` = 1;
  - SCK is at the `cpol` level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Character to transmit |
| rd_en | input | 1 | Removes the oldest received character |
| rd_data | output | 8 | Oldest received character |
| rx_enable | input | 1 | 1 stores received characters, 0 discards them |
| lsb_first | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| cpol | input | 1 | SCK rest level |
| cpha | input | 1 | 0 samples on leading edge, 1 on trailing edge |
| hw_ss | input | 1 | 1 lets the block drive `ss_n` |
| tx_empty | output | 1 | Transmit holding register can take a character |
| rx_ready | output | 1 | At least one received character is waiting |
| rx_overflow | output | 1 | Sticky: a received character was lost |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The assertions assume that `cpol`, `cpha`, `lsb_first`, `hw_ss` and `rx_enable` change only while the engine is idle: `ss_n` is high and no character is queued or shifting. This matters in particular for the checks on SCK level and SS framing. The stimulus respects this. It picks a new random configuration only after every queued character has left the wire and the trailing half period has passed. It masks its own SCK observer while the rest level moves. MISO is driven by a bench slave model that presents the next bit only just after each sampling edge, so the engine always samples a settled value.

// File: rtl/spi_eng_pkg.sv
// Shared types and constants for the SPI master engine.
// Assumes 8-bit characters; CHAR_W must be a power of two.
package spi_eng_pkg;

    localparam int CHAR_W = 8;
    localparam int EDGE_W = $clog2(2 * CHAR_W);

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SHIFT = 2'd1,
        SEQ_TRAIL = 2'd2
    } seq_state_t;

endpackage

// File: rtl/spi_eng_clkgen.sv
// SCK generator: produces a tick every HALF_DIV clocks while running and
// toggles SCK on requested edges; parks SCK at cpol when not running.
// Assumes HALF_DIV >= 1 and cpol steady while running.
module spi_eng_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic toggle,
    input  logic cpol,
    output logic tick,
    output logic sck
);

    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    generate
        if (HALF_DIV == 1) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
            logic [CNT_W-1:0] cnt_q;

            // Half-period counter, held at zero while idle.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    cnt_q <= '0;
                end else if (cnt_q == CNT_LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = run && (cnt_q == CNT_LAST);
        end
    endgenerate

    // SCK level: rest at cpol, flip on each requested edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sck <= cpol;
        end else if (toggle) begin
            sck <= ~sck;
        end
    end

endmodule

// File: rtl/spi_eng_shifter.sv
// Combined transmit/receive shift register with a registered MOSI bit.
// Samples MISO into the register on sampling edges and updates MOSI on
// changing edges. rx_char is the character as it stands after the current
// sample, used by the caller in the cycle of the last sampling edge.
// Assumes load and sample are never needed on the same register bit.
module spi_eng_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lsb_first,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         preset_out,
    input  logic         sample,
    input  logic         change,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] rx_char
);

    logic [W-1:0] sh_q;
    logic         out_bit;
    logic         first_bit;

    assign out_bit   = lsb_first ? sh_q[0] : sh_q[W-1];
    assign first_bit = lsb_first ? load_data[0] : load_data[W-1];
    assign rx_char   = lsb_first ? {miso, sh_q[W-1:1]} : {sh_q[W-2:0], miso};

    // Shift register: new character on load, else shift MISO in on sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_data;
        end else if (sample) begin
            sh_q <= rx_char;
        end
    end

    // MOSI register: first bit on preset, next bit on each changing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mosi <= 1'b0;
        end else if (preset_out) begin
            mosi <= first_bit;
        end else if (change) begin
            mosi <= out_bit;
        end
    end

endmodule

// File: rtl/spi_eng_rxbuf.sv
// Small receive FIFO with a sticky overflow flag. A push into a full FIFO
// succeeds only if a pop frees an entry in the same cycle.
// Assumes DEPTH is a power of two and at least 2.
module spi_eng_rxbuf #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty,
    output logic         overflow
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pop_ok;
    logic             push_ok;
    logic             blocked;

    assign pop_ok    = pop && (cnt_q != '0);
    assign blocked   = (cnt_q == FULL_CNT) && !pop_ok;
    assign push_ok   = push && !blocked;
    assign dout      = mem_q[rd_ptr_q];
    assign not_empty = (cnt_q != '0);

    // Entry storage, written at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[wr_ptr_q] <= din;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Sticky overflow on a refused push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (push && blocked) begin
            overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/spi_master_engine.sv
// SPI master engine top: transmit holding register, transfer sequencer,
// SCK generator, shift register and receive FIFO. The sequencer counts
// 2*CHAR_W SCK edges per character and chains straight into the next
// character when the holding register is full at the last edge.
// Assumes the mode, order, hw_ss and rx_enable inputs change only while idle.
module spi_master_engine
    import spi_eng_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int RX_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [CHAR_W-1:0] rd_data,
    input  logic              rx_enable,
    input  logic              lsb_first,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              hw_ss,
    output logic              tx_empty,
    output logic              rx_ready,
    output logic              rx_overflow,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);

    localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(2 * CHAR_W - 1);

    seq_state_t        state_q, state_d;
    logic [EDGE_W-1:0] edge_q;
    logic [CHAR_W-1:0] hold_q;
    logic              hold_vld_q;
    logic              tick;
    logic              in_shift;
    logic              last_edge;
    logic              load_idle;
    logic              reload;
    logic              load;
    logic              sample_edge;
    logic              change_edge;
    logic              char_done;
    logic [CHAR_W-1:0] rx_char;

    assign in_shift    = (state_q == SEQ_SHIFT);
    assign last_edge   = tick && in_shift && (edge_q == EDGE_LAST);
    assign load_idle   = (state_q == SEQ_IDLE) && hold_vld_q;
    assign reload      = last_edge && hold_vld_q;
    assign load        = load_idle || reload;
    assign sample_edge = tick && in_shift && (edge_q[0] == cpha);
    assign change_edge = tick && in_shift && (edge_q[0] != cpha);
    assign char_done   = sample_edge && (&edge_q[EDGE_W-1:1]);
    assign tx_empty    = !hold_vld_q;

    // Transmit holding register: accept when empty, release on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld_q <= 1'b0;
            hold_q     <= '0;
        end else if (load) begin
            hold_vld_q <= 1'b0;
        end else if (wr_en && !hold_vld_q) begin
            hold_vld_q <= 1'b1;
            hold_q     <= wr_data;
        end
    end

    // Sequencer next state.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_IDLE:  if (hold_vld_q) state_d = SEQ_SHIFT;
            SEQ_SHIFT: if (last_edge && !hold_vld_q) state_d = SEQ_TRAIL;
            SEQ_TRAIL: if (tick) state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    // Sequencer state, edge counter and registered slave select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            edge_q  <= '0;
            ss_n    <= 1'b1;
        end else begin
            state_q <= state_d;
            ss_n    <= !(hw_ss && (state_d != SEQ_IDLE));
            if (load) begin
                edge_q <= '0;
            end else if (tick && in_shift) begin
                edge_q <= edge_q + 1'b1;
            end
        end
    end

    spi_eng_clkgen #(
        .HALF_DIV (HALF_DIV)
    ) i_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q != SEQ_IDLE),
        .toggle (tick && in_shift),
        .cpol   (cpol),
        .tick   (tick),
        .sck    (sck)
    );

    spi_eng_shifter #(
        .W (CHAR_W)
    ) i_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .lsb_first  (lsb_first),
        .load       (load),
        .load_data  (hold_q),
        .preset_out (load_idle || (reload && !cpha)),
        .sample     (sample_edge),
        .change     (change_edge),
        .miso       (miso),
        .mosi       (mosi),
        .rx_char    (rx_char)
    );

    spi_eng_rxbuf #(
        .W     (CHAR_W),
        .DEPTH (RX_DEPTH)
    ) i_rxbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (char_done && rx_enable),
        .din       (rx_char),
        .pop       (rd_en),
        .dout      (rd_data),
        .not_empty (rx_ready),
        .overflow  (rx_overflow)
    );

endmodule

// File: rtl/spi_eng_checker.sv
// Protocol checks on the ports of spi_master_engine, attached by bind.
// Assumes the control inputs change only while the engine is idle.
module spi_eng_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic rd_en,
    input logic rx_enable,
    input logic cpol,
    input logic hw_ss,
    input logic tx_empty,
    input logic rx_ready,
    input logic rx_overflow,
    input logic sck,
    input logic ss_n
);

    AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty && wr_en |=> !tx_empty); // R1

    AST_RXC_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable && !rx_ready |=> !rx_ready); // R6

    AST_RXC_CLEARS_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_ready) |-> $past(rd_en)); // R5

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |=> rx_overflow); // R7

    AST_SCK_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ss && (sck != $past(sck)) && (sck != cpol) |-> !ss_n); // R8

    AST_SCK_RESTS_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ss && $rose(ss_n) |-> (sck == cpol)); // R4

endmodule

bind spi_master_engine spi_eng_checker i_spi_eng_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .rx_enable   (rx_enable),
    .cpol        (cpol),
    .hw_ss       (hw_ss),
    .tx_empty    (tx_empty),
    .rx_ready    (rx_ready),
    .rx_overflow (rx_overflow),
    .sck         (sck),
    .ss_n        (ss_n)
);

// File: tb/test_spi_master_engine.sv
`timescale 1ns/1ps
// Bench: a slave model drives MISO and decodes MOSI on sampling edges, and
// the main sequence runs directed cases then random configurations.
module test_spi_master_engine;

    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rx_enable = 1'b0;
    logic       lsb_first = 1'b0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       hw_ss = 1'b0;
    logic       tx_empty, rx_ready, rx_overflow, sck, mosi, miso, ss_n;

    always #2 clk = ~clk;

    spi_master_engine #(.HALF_DIV(HALF), .RX_DEPTH(2)) i_spi_master_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rx_enable(rx_enable),
        .lsb_first(lsb_first), .cpol(cpol), .cpha(cpha), .hw_ss(hw_ss),
        .tx_empty(tx_empty), .rx_ready(rx_ready), .rx_overflow(rx_overflow),
        .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    logic [7:0] sent [512];
    logic [7:0] pat  [512];
    int  wr_idx = 0;
    bit  quiet  = 1'b1;
    int  n_tests = 0, n_fail = 0;

    // ---------------- slave model / monitor ----------------
    int  m_tests = 0, m_fail = 0;
    int  cyc = 0, last_sck_cyc = 0, ss_fall_cyc = 0;
    int  bit_cnt = 0, mon_idx = 0, ss_falls = 0;
    bit  lead_pend = 1'b0;
    logic sck_prev = 1'b0, ss_prev = 1'b1;
    logic [7:0] acc = '0;

    function automatic logic pat_bit(logic [7:0] b, int n, logic lsb);
        if (n > 7) return 1'b0;
        return lsb ? b[n] : b[7-n];
    endfunction

    assign miso = pat_bit(pat[mon_idx], bit_cnt, lsb_first);

    task automatic mchk(bit ok, string tag, int act, int exp);
        m_tests++;
        if (!ok) begin
            m_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Decode SCK edges, check MOSI characters and SS lead/trail spacing.
    always @(negedge clk) begin
        logic [7:0] nacc;
        cyc <= cyc + 1;
        if (!rst_n) begin
            sck_prev <= sck;
            ss_prev  <= ss_n;
        end else begin
            if (sck !== sck_prev && !quiet) begin
                last_sck_cyc <= cyc;
                if (lead_pend) begin
                    mchk(cyc - ss_fall_cyc == HALF, "R8 ss lead", cyc - ss_fall_cyc, HALF);
                    lead_pend <= 1'b0;
                end
                if ((sck != cpol) == (cpha == 1'b0)) begin
                    nacc = lsb_first ? {mosi, acc[7:1]} : {acc[6:0], mosi};
                    acc <= nacc;
                    if (bit_cnt == 7) begin
                        mchk(nacc == sent[mon_idx], "R3 R4 mosi char", nacc, sent[mon_idx]);
                        mon_idx <= mon_idx + 1;
                        bit_cnt <= 0;
                    end else begin
                        bit_cnt <= bit_cnt + 1;
                    end
                end
            end
            if (ss_prev && !ss_n) begin
                ss_fall_cyc <= cyc;
                lead_pend   <= 1'b1;
                ss_falls    <= ss_falls + 1;
            end
            if (!ss_prev && ss_n)
                mchk(cyc - last_sck_cyc == HALF, "R8 ss trail", cyc - last_sck_cyc, HALF);
            sck_prev <= sck;
            ss_prev  <= ss_n;
        end
    end

    // ---------------- main sequence ----------------
    task automatic chk(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(logic pol, logic pha, logic lsb, logic rxe, logic hss);
        @(negedge clk);
        quiet = 1'b1;
        cpol = pol; cpha = pha; lsb_first = lsb; rx_enable = rxe; hw_ss = hss;
        repeat (3) @(negedge clk);
        quiet = 1'b0;
    endtask

    task automatic send(logic [7:0] d, logic [7:0] p);
        while (!tx_empty) @(negedge clk);
        sent[wr_idx] = d;
        pat[wr_idx]  = p;
        wr_idx++;
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        while (mon_idx != wr_idx || !tx_empty) @(negedge clk);
        repeat (4 * HALF + 2) @(negedge clk);
    endtask

    initial begin
        bit ovf_exp = 1'b0;
        void'($urandom(32'd24681));
        repeat (4) @(negedge clk);
        // R9: state under reset
        chk(tx_empty == 1'b1, "R9 tx_empty", tx_empty, 1);
        chk(rx_ready == 1'b0, "R9 rx_ready", rx_ready, 0);
        chk(rx_overflow == 1'b0, "R9 rx_overflow", rx_overflow, 0);
        chk(ss_n == 1'b1, "R9 ss_n", ss_n, 1);
        chk(sck == 1'b0, "R9 sck", sck, 0);
        rst_n = 1'b1;
        set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

        // Directed: R1 holding handoff, R2 dropped write, R8 SS low
        begin
            int base = wr_idx;
            sent[wr_idx] = 8'hA5; pat[wr_idx] = 8'h3C; wr_idx++;
            wr_en = 1'b1; wr_data = 8'hA5;
            @(negedge clk);
            wr_en = 1'b0;
            chk(tx_empty == 1'b0, "R1 held after write", tx_empty, 0);
            @(negedge clk);
            chk(tx_empty == 1'b1, "R1 empty after move", tx_empty, 1);
            chk(ss_n == 1'b0, "R8 ss low on start", ss_n, 0);
            sent[wr_idx] = 8'h5A; pat[wr_idx] = 8'hC3; wr_idx++;
            wr_en = 1'b1; wr_data = 8'h5A;
            @(negedge clk);
            wr_en = 1'b1; wr_data = 8'hFF;   // R2: holding full, dropped
            @(negedge clk);
            wr_en = 1'b0;
            repeat (8) @(negedge clk);
            chk(tx_empty == 1'b0, "R1 waits for shifter", tx_empty, 0);
            drain();
            repeat (40) @(negedge clk);
            chk(mon_idx == base + 2, "R2 dropped write unsent", mon_idx - base, 2);
            chk(rx_ready == 1'b0, "R6 discard rx", rx_ready, 0);
        end

        // Random configurations with directed-sized bursts
        for (int t = 0; t < 48; t++) begin
            logic pol = 1'($urandom);
            logic pha = 1'($urandom);
            logic lsb = 1'($urandom);
            logic rxe = (t < 4) ? 1'b1 : 1'($urandom);
            logic hss = 1'($urandom);
            int   n   = (t < 4) ? 3 : 1 + int'($urandom % 3);
            int   base;
            int   k;
            int   ss0;
            set_cfg(pol, pha, lsb, rxe, hss);
            chk(sck == pol, "R4 sck rest level", sck, pol);
            chk(ss_n == 1'b1, "R8 ss idle high", ss_n, 1);
            base = wr_idx;
            ss0  = ss_falls;
            for (int i = 0; i < n; i++) send(8'($urandom), 8'($urandom));
            drain();
            chk(ss_falls - ss0 == (hss ? 1 : 0), "R8 one frame per burst", ss_falls - ss0, hss ? 1 : 0);
            k = rxe ? ((n > 2) ? 2 : n) : 0;
            if (rxe && n > 2) ovf_exp = 1'b1;
            if (rxe)
                chk(rx_ready == (k > 0), "R5 rx_ready set", rx_ready, k > 0);
            else
                chk(rx_ready == 1'b0, "R6 rx_ready unchanged", rx_ready, 0);
            for (int j = 0; j < k; j++) begin
                chk(rd_data == pat[base+j], "R3 R5 received char", rd_data, pat[base+j]);
                rd_en = 1'b1;
                @(negedge clk);
                rd_en = 1'b0;
            end
            chk(rx_ready == 1'b0, "R5 rx_ready auto clear", rx_ready, 0);
            chk(rx_overflow == ovf_exp, "R7 overflow flag", rx_overflow, ovf_exp);
        end

        repeat (5) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests + m_tests, n_fail + m_fail);
        $finish;
    end

    // Watchdog: a hung run is reported as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=%0d expected=%0d", mon_idx, wr_idx);
        $display("  [TB] %0d tests run, %0d failed", n_tests + m_tests + 1, n_fail + m_fail + 1);
        $finish;
    end

endmodule